// File: doc/BRIEF.md
# Device error status register

This block holds the error status word of one port on a serial point-to-point link, such as an endpoint or a bridge port. Logic elsewhere in the port detects errors and sends single-cycle pulses into the block, one pulse input for each error class. The block latches each class in a sticky flag. Software reads the 16-bit word through a simple select/write/byte-enable port. It clears a flag by writing a one to that flag's bit position. Writing a zero leaves the flag as it is.

An unsupported-request pulse has two effects. It sets its own flag. It also sets either the non-fatal summary flag or the fatal summary flag, and a severity control input chooses which one. Logging is never gated: the block has no reporting-enable input and no mask input. The only flags are for errors that this port detects itself, not for error messages received from the far end of the link.

The word also carries a live "requests outstanding" bit. This bit follows an input flag directly and holds no state.

Top module: `devstat_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, every flag clears. After that edge `rdata[3:0]` reads 0.
- R2: A pulse on `ev_corr` sets bit 0 (correctable) at the next rising edge and leaves every other flag unchanged.
- R3: A pulse on `ev_nonfatal` sets bit 1, and a pulse on `ev_fatal` sets bit 2, each at the next rising edge.
- R4: A pulse on `ev_unsup` sets bit 3 (unsupported request). In the same edge it also sets bit 1 when `unsup_is_fatal` is 0, or bit 2 when `unsup_is_fatal` is 1.
- R5: A set flag stays at 1 until a clear write reaches it or reset occurs. No input can gate or mask event logging.
- R6: A write cycle is a cycle with `sel`, `wr_en` and `be[0]` all high. In a write cycle, a 1 in `wdata[k]` for k in 0..3 clears flag k at the edge. A 0 in `wdata[k]` leaves flag k unchanged. If `sel`, `wr_en` or `be[0]` is low, no flag changes.
- R7: If a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up at 1.
- R8: `rdata[5]` equals `pend_live` in the same cycle, combinationally, and no write affects it.
- R9: `rdata[15:6]` and `rdata[4]` always read 0, whatever the writes, including writes with `be[1]` high.
- R10: Reading has no side effects. `rdata` depends only on the flags and `pend_live`, and holding `sel` high without `wr_en` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Register select strobe |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| be | input | 2 | Byte enables: bit 0 covers data bits 7:0, bit 1 covers bits 15:8 |
| wdata | input | 16 | Write data; a 1 clears the matching flag |
| rdata | output | 16 | Current status word |
| ev_corr | input | 1 | Correctable error pulse |
| ev_nonfatal | input | 1 | Non-fatal error pulse |
| ev_fatal | input | 1 | Fatal error pulse |
| ev_unsup | input | 1 | Unsupported-request pulse |
| unsup_is_fatal | input | 1 | Severity for unsupported requests: 0 non-fatal, 1 fatal |
| pend_live | input | 1 | Requests still awaiting completion |

## Verification
Each flag passes through exactly one register. An event pulse or a clearing write presented before a rising edge is therefore visible on `rdata` right after that edge, and it counts as due one cycle after the stimulus. The pending bit goes through no register and is due in the same cycle. The bench drives all inputs on the falling edge and compares `rdata` with its own model on the next falling edge, which lies half a period after the edge where the change is due. For the pending bit it compares within the same low phase in which it changed `pend_live`.

// File: rtl/devstat_pkg.sv
package devstat_pkg;

    localparam int REG_W   = 16;
    localparam int FLAG_N  = 4;
    localparam int CE_POS  = 0;
    localparam int NF_POS  = 1;
    localparam int FE_POS  = 2;
    localparam int UR_POS  = 3;
    localparam int TP_POS  = 5;

    // Error event bundle, packed in flag-bit order (ur is the msb).
    typedef struct packed {
        logic ur;
        logic fe;
        logic nf;
        logic ce;
    } err_vec_t;

    typedef enum logic {
        SEV_NONFATAL = 1'b0,
        SEV_FATAL    = 1'b1
    } ur_sev_e;

    // Route the raw event pulses onto the flag bits they set.
    function automatic err_vec_t route_events(input err_vec_t raw, input ur_sev_e sev);
        err_vec_t r;
        r    = raw;
        r.nf = raw.nf | (raw.ur & (sev == SEV_NONFATAL));
        r.fe = raw.fe | (raw.ur & (sev == SEV_FATAL));
        return r;
    endfunction

endpackage

// File: rtl/devstat_evmap.sv
module devstat_evmap
    import devstat_pkg::*;
(
    input  logic     ev_corr,
    input  logic     ev_nonfatal,
    input  logic     ev_fatal,
    input  logic     ev_unsup,
    input  logic     unsup_is_fatal,
    output err_vec_t set_v
);
    err_vec_t raw;
    ur_sev_e  sev;

    always_comb begin
        raw.ce = ev_corr;
        raw.nf = ev_nonfatal;
        raw.fe = ev_fatal;
        raw.ur = ev_unsup;
        sev    = unsup_is_fatal ? SEV_FATAL : SEV_NONFATAL;
        set_v  = route_events(raw, sev);
    end
endmodule

// File: rtl/devstat_flagbank.sv
module devstat_flagbank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    q[i] <= 1'b0;
                else if (set_v[i])
                    q[i] <= 1'b1;          // a set beats a clear in the same cycle
                else if (clr_v[i])
                    q[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/devstat_rdmux.sv
module devstat_rdmux
    import devstat_pkg::*;
(
    input  err_vec_t         flags,
    input  logic             pend_live,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata                     = '0;
        rdata[UR_POS:CE_POS]      = flags;
        rdata[TP_POS]             = pend_live;
    end
endmodule

// File: rtl/devstat_reg.sv
module devstat_reg
    import devstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             wr_en,
    input  logic [1:0]       be,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             ev_corr,
    input  logic             ev_nonfatal,
    input  logic             ev_fatal,
    input  logic             ev_unsup,
    input  logic             unsup_is_fatal,
    input  logic             pend_live
);
    err_vec_t          set_v;
    err_vec_t          clr_v;
    err_vec_t          flags;
    logic              wr_lo;
    logic              unused_hi;

    devstat_evmap u_evmap (
        .ev_corr        (ev_corr),
        .ev_nonfatal    (ev_nonfatal),
        .ev_fatal       (ev_fatal),
        .ev_unsup       (ev_unsup),
        .unsup_is_fatal (unsup_is_fatal),
        .set_v          (set_v)
    );

    // Only the low byte holds writable flags; the high byte is all reserved.
    assign wr_lo     = sel & wr_en & be[0];
    assign clr_v     = wr_lo ? err_vec_t'(wdata[UR_POS:CE_POS]) : '0;
    assign unused_hi = ^{be[1], wdata[REG_W-1:FLAG_N]};

    devstat_flagbank #(.N(FLAG_N)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .q     (flags)
    );

    devstat_rdmux u_rdmux (
        .flags     (flags),
        .pend_live (pend_live),
        .rdata     (rdata)
    );
endmodule

// File: rtl/devstat_chk.sv
module devstat_chk
    import devstat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sel,
    input logic             wr_en,
    input logic [1:0]       be,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic             ev_corr,
    input logic             ev_nonfatal,
    input logic             ev_fatal,
    input logic             ev_unsup,
    input logic             unsup_is_fatal,
    input logic             pend_live
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: one edge after reset was sampled, no flag is set
    always_ff @(negedge clk)
        if (rst_q) a_r1_reset_clear: assert (rdata[3:0] == 4'h0);

    a_r2_corr_sets: assert property (@(posedge clk) disable iff (rst)
        ev_corr |=> rdata[CE_POS]);

    a_r3_fatal_sets: assert property (@(posedge clk) disable iff (rst)
        ev_fatal |=> rdata[FE_POS]);

    a_r4_ur_nonfatal: assert property (@(posedge clk) disable iff (rst)
        (ev_unsup && !unsup_is_fatal) |=> (rdata[UR_POS] && rdata[NF_POS]));

    a_r4_ur_fatal: assert property (@(posedge clk) disable iff (rst)
        (ev_unsup && unsup_is_fatal) |=> (rdata[UR_POS] && rdata[FE_POS]));

    a_r5_sticky_ce: assert property (@(posedge clk) disable iff (rst)
        (rdata[CE_POS] && !(sel && wr_en && be[0] && wdata[CE_POS])) |=> rdata[CE_POS]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_corr && sel && wr_en && be[0] && wdata[CE_POS]) |=> rdata[CE_POS]);

    a_r8_pending: assert property (@(posedge clk) disable iff (rst)
        rdata[TP_POS] == pend_live);

    a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
        (rdata[REG_W-1:6] == '0) && !rdata[4]);
endmodule

bind devstat_reg devstat_chk u_chk (.*);

// File: tb/devstat_reg_tb.sv
module devstat_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr_en = 1'b0;
    logic [1:0]  be = 2'b00;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ev_corr = 0, ev_nonfatal = 0, ev_fatal = 0, ev_unsup = 0;
    logic        unsup_is_fatal = 0, pend_live = 0;

    int total = 0;
    int bad   = 0;
    logic [3:0] model = 4'h0;

    always #2 clk = ~clk;   // 250 MHz

    devstat_reg dut_i (.*);

    task automatic check(input string req, input logic [15:0] exp);
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
        end
    endtask

    function automatic logic [15:0] expect_word();
        return {10'h0, pend_live, 1'b0, model};
    endfunction

    // One cycle: drive at falling edge, compare after the next rising edge.
    task automatic cycle(input logic [3:0] ev, input logic sev,
                         input logic s, input logic w, input logic [1:0] b,
                         input logic [15:0] d, input string req);
        logic [3:0] setm, clrm;
        @(negedge clk);
        {ev_unsup, ev_fatal, ev_nonfatal, ev_corr} = ev;
        unsup_is_fatal = sev;
        sel = s; wr_en = w; be = b; wdata = d;
        setm = {ev[3], ev[2] | (ev[3] & sev), ev[1] | (ev[3] & ~sev), ev[0]};
        clrm = (s & w & b[0]) ? d[3:0] : 4'h0;
        model = (model & ~clrm) | setm;
        @(negedge clk);
        {ev_unsup, ev_fatal, ev_nonfatal, ev_corr} = 4'h0;
        sel = 0; wr_en = 0; be = 0; wdata = 0;
        check(req, expect_word());
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run hung, expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        model = 4'h0;
        check("R1 reset", 16'h0000);

        // R2 R3 R4: sweep every event combination and both severities
        for (int v = 0; v < 32; v++) begin
            cycle(v[3:0], v[4], 0, 0, 2'b00, 16'h0, "R2/R3/R4 event sweep");
            cycle(4'h0, 0, 1, 1, 2'b01, 16'h000F, "R6 clear all");
        end

        // R5: flags stay set over idle cycles
        cycle(4'b0101, 0, 0, 0, 0, 0, "R5 set");
        for (int k = 0; k < 5; k++) cycle(4'h0, 0, 0, 0, 0, 0, "R5 sticky hold");

        // R6: partial clears, zeros ignored, missing qualifiers ignored
        cycle(4'b1111, 0, 0, 0, 0, 0, "R6 set all");
        cycle(4'h0, 0, 1, 1, 2'b01, 16'h0000, "R6 write zero no effect");
        cycle(4'h0, 0, 1, 1, 2'b10, 16'h000F, "R6 be0 low no effect");
        cycle(4'h0, 0, 0, 1, 2'b01, 16'h000F, "R6 sel low no effect");
        cycle(4'h0, 0, 1, 0, 2'b01, 16'h000F, "R6 wr_en low no effect");
        cycle(4'h0, 0, 1, 1, 2'b01, 16'h0005, "R6 partial clear");
        cycle(4'h0, 0, 1, 1, 2'b01, 16'h0008, "R6 clear ur only");

        // R7: set and clear same cycle
        for (int b = 0; b < 4; b++)
            cycle(4'(1 << b), 1, 1, 1, 2'b01, 16'h000F, "R7 set wins");
        cycle(4'h0, 0, 1, 1, 2'b01, 16'h000F, "R7 cleanup");

        // R8: pending bit follows input, writes do not touch it
        for (int p = 0; p < 2; p++) begin
            @(negedge clk); pend_live = p[0]; #1;
            check("R8 pending live", expect_word());
            cycle(4'h0, 0, 1, 1, 2'b11, 16'hFFFF, "R8 write ignored on pending");
        end

        // R9: reserved bits read zero under full writes
        cycle(4'b1111, 0, 1, 1, 2'b11, 16'hFFF0, "R9 reserved zero");
        cycle(4'h0, 0, 1, 1, 2'b10, 16'hFFFF, "R9 high byte write");

        // R10: reads with sel only change nothing
        for (int k = 0; k < 3; k++) cycle(4'h0, 0, 1, 0, 2'b11, 16'hFFFF, "R10 read no side effect");

        // R1 again: reset from a populated state
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; model = 4'h0;
        check("R1 reset clears flags", expect_word());

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule